// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a chip. It turns processor I/O accesses into configuration transactions on a simple target-side configuration bus. Two 32-bit I/O locations are decoded. The address port at 0xCF8 holds a configuration pointer. The data port at 0xCFC is a window: each access to it, while the pointer's enable bit is set, becomes exactly one configuration request. The request carries the register number, the function number, the I/O byte enables and, on writes, the I/O data. The target is picked by a one-hot select line decoded from the device number, much like a chip select.

When the window is disabled, the bus number is not zero, or no target acknowledges within a bounded time, the block completes the I/O access by itself. Reads then return all ones and write data is dropped. A processor can therefore probe every device slot without any error path. Every accepted I/O access is finished by a single-cycle done pulse. The host raises `io_req` for one cycle and then waits for that pulse before it issues the next access.

Top module: `cfg_port_bridge`

## Requirements
- R1: The address port (I/O address 0xCF8) is written lane by lane. Byte enable bit k writes data bits 8k+7..8k. A read returns bit 31 as enable, bits 23..16 as bus, bits 15..11 as device, bits 10..8 as function and bits 7..2 as register number. Bits 30..24 and 1..0 always read as 0.
- R2: A data-port (0xCFC) access while the enable bit is 0 issues no request (`cfg_req` stays 0). It completes with `io_done` in the cycle after `io_req` is sampled, and a read returns 0xFFFFFFFF.
- R3: A data-port access with enable 1, bus 0 and a device below NUM_DEV raises `cfg_req` from the cycle after acceptance. `cfg_req` stays high until the cycle in which `cfg_ack` is sampled high. While it is high, `cfg_reg`, `cfg_fn`, `cfg_be`, `cfg_wr` and `cfg_wdata` carry the register number, the function number, the I/O byte enables, the access direction (1 = write) and the I/O write data.
- R4: While `cfg_req` is high, `dev_sel` has exactly bit <device number> set. Otherwise it is all zeros.
- R5: On a claimed read, `io_rdata` equals `cfg_rdata` unchanged, with byte lane 0 as the least significant byte. `io_done` rises in the cycle after `cfg_ack` is sampled.
- R6: If no acknowledge arrives, `cfg_req` stays high for exactly TIMEOUT (16) cycles and then drops. The access completes in the next cycle, and a read returns 0xFFFFFFFF. An acknowledge sampled in the 16th cycle is still accepted.
- R7: With enable 1 and a non-zero bus number, a data-port access issues no request and completes like an absent device: done in the next cycle, and a read returns all ones.
- R8: An access to any other I/O address completes in the next cycle. A read returns all ones, and a write leaves the address port unchanged.
- R9: `io_done` is high for exactly one cycle per accepted access.
- R10: After reset the address port reads 0, and `cfg_req`, `dev_sel` and `io_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | I/O access request, one-cycle pulse while idle |
| io_wr | input | 1 | 1 = I/O write, 0 = I/O read |
| io_addr | input | 16 | I/O address |
| io_be | input | 4 | I/O byte enables, bit k for byte lane k |
| io_wdata | input | 32 | I/O write data |
| io_done | output | 1 | Access completion pulse |
| io_rdata | output | 32 | I/O read data, valid with io_done on reads |
| cfg_req | output | 1 | Configuration request active |
| cfg_wr | output | 1 | Configuration request is a write |
| cfg_reg | output | 6 | Dword register number |
| cfg_fn | output | 3 | Function number |
| cfg_be | output | 4 | Byte enables of the request |
| cfg_wdata | output | 32 | Configuration write data |
| dev_sel | output | 32 | One-hot target select, bit per device number |
| cfg_ack | input | 1 | Target acknowledge |
| cfg_rdata | input | 32 | Target read data, valid with cfg_ack |

## Verification
A corrupted pointer register would show up at once on the next address-port read. It would also show up on the very next claimed access, as a wrong `dev_sel` bit or a wrong `cfg_reg` or `cfg_fn` value. A bad transaction state shows as a missing or doubled `io_done`, or as a `cfg_req` that outlives its acknowledge. A wrong timeout count shifts the completion cycle by a predictable number of cycles, within at most 17 cycles of the request. The sweep covers all 32 device slots with varied functions, registers, byte enables and acknowledge delays, and it times every completion to the exact cycle.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } txn_state_t;

  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;
  localparam int EN_POS   = 31;
  localparam int BUS_LSB  = 16;
  localparam int BUS_W    = 8;
  localparam int DEV_LSB  = 11;
  localparam int DEV_W    = 5;
  localparam int FN_LSB   = 8;
  localparam int FN_W     = 3;
  localparam int REG_LSB  = 2;
  localparam int REG_W    = 6;
  localparam logic [DATA_W-1:0] PTR_KEEP = 32'h80FF_FFFC;
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] ptr_q;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] ptr_d;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign merged[8*g +: 8] = (wr_en && be[g]) ? wdata[8*g +: 8] : ptr_q[8*g +: 8];
    end
  endgenerate

  always_comb ptr_d = merged & PTR_KEEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (wr_en) ptr_q <= ptr_d;
  end

  assign value = ptr_q;

  assert_ptr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(value));
endmodule

// File: rtl/cfg_sel_decode.sv
module cfg_sel_decode
  import cfg_bridge_pkg::*;
#(
  parameter int NUM_DEV = 32
) (
  input  logic             en,
  input  logic [DEV_W-1:0] dev,
  output logic [NUM_DEV-1:0] sel
);
  genvar g;
  generate
    for (g = 0; g < NUM_DEV; g++) begin : g_sel
      assign sel[g] = en && (dev == DEV_W'(g));
    end
  endgenerate
endmodule

// File: rtl/cfg_txn_fsm.sv
module cfg_txn_fsm
  import cfg_bridge_pkg::*;
#(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_remote,
  input  logic start_local,
  input  logic ack,
  output logic idle,
  output logic waiting,
  output logic done,
  output logic fin_ack,
  output logic fin_tmo
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  txn_state_t state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    fin_ack = 1'b0;
    fin_tmo = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_remote) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end else if (start_local) begin
          state_d = ST_RESP;
        end
      end
      ST_WAIT: begin
        cnt_en = 1'b1;
        if (ack) begin
          fin_ack = 1'b1;
          state_d = ST_RESP;
        end else if (cnt_q == CNT_W'(TIMEOUT - 1)) begin
          fin_tmo = 1'b1;
          state_d = ST_RESP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign idle    = (state_q == ST_IDLE);
  assign waiting = (state_q == ST_WAIT);
  assign done    = (state_q == ST_RESP);

  assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (cnt_q < CNT_W'(TIMEOUT)));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfg_bridge_pkg::*;
#(
  parameter int          NUM_DEV   = 32,
  parameter int          TIMEOUT   = 16,
  parameter int          IO_AW     = 16,
  parameter logic [15:0] PTR_PORT  = 16'h0CF8,
  parameter logic [15:0] WIN_PORT  = 16'h0CFC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                io_req,
  input  logic                io_wr,
  input  logic [IO_AW-1:0]    io_addr,
  input  logic [3:0]          io_be,
  input  logic [31:0]         io_wdata,
  output logic                io_done,
  output logic [31:0]         io_rdata,
  output logic                cfg_req,
  output logic                cfg_wr,
  output logic [5:0]          cfg_reg,
  output logic [2:0]          cfg_fn,
  output logic [3:0]          cfg_be,
  output logic [31:0]         cfg_wdata,
  output logic [NUM_DEV-1:0]  dev_sel,
  input  logic                cfg_ack,
  input  logic [31:0]         cfg_rdata
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [DATA_W-1:0] ptr;
  logic idle, waiting, fin_ack, fin_tmo;
  logic accept, hit_ptr, hit_win, ptr_en, bus_zero, dev_ok, go_remote, go_local;
  logic [DEV_W-1:0] ptr_dev;

  logic              wr_q, wr_d;
  logic [LANES-1:0]  be_q, be_d;
  logic [DATA_W-1:0] wdat_q, wdat_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              rdat_en;

  assign accept   = io_req && idle;
  assign hit_ptr  = (io_addr == IO_AW'(PTR_PORT));
  assign hit_win  = (io_addr == IO_AW'(WIN_PORT));
  assign ptr_en   = ptr[EN_POS];
  assign bus_zero = (ptr[BUS_LSB +: BUS_W] == '0);
  assign ptr_dev  = ptr[DEV_LSB +: DEV_W];
  assign dev_ok   = ({1'b0, ptr_dev} < (DEV_W+1)'(NUM_DEV));
  assign go_remote = accept && hit_win && ptr_en && bus_zero && dev_ok;
  assign go_local  = accept && !go_remote;

  cfg_addr_reg u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (accept && hit_ptr && io_wr),
    .be    (io_be),
    .wdata (io_wdata),
    .value (ptr)
  );

  cfg_txn_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_remote (go_remote),
    .start_local  (go_local),
    .ack          (cfg_ack),
    .idle         (idle),
    .waiting      (waiting),
    .done         (io_done),
    .fin_ack      (fin_ack),
    .fin_tmo      (fin_tmo)
  );

  cfg_sel_decode #(.NUM_DEV(NUM_DEV)) u_sel (
    .en  (waiting),
    .dev (ptr_dev),
    .sel (dev_sel)
  );

  always_comb begin
    wr_d    = io_wr;
    be_d    = io_be;
    wdat_d  = io_wdata;
    rdat_en = 1'b1;
    if (go_local)     rdat_d = (hit_ptr && !io_wr) ? ptr : ALL_ONES;
    else if (fin_ack) rdat_d = cfg_rdata;
    else if (fin_tmo) rdat_d = ALL_ONES;
    else begin
      rdat_d  = rdat_q;
      rdat_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      be_q   <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      if (go_remote) begin
        wr_q   <= wr_d;
        be_q   <= be_d;
        wdat_q <= wdat_d;
      end
      if (rdat_en) rdat_q <= rdat_d;
    end
  end

  assign cfg_req   = waiting;
  assign cfg_wr    = wr_q;
  assign cfg_be    = be_q;
  assign cfg_wdata = wdat_q;
  assign cfg_reg   = ptr[REG_LSB +: REG_W];
  assign cfg_fn    = ptr[FN_LSB +: FN_W];
  assign io_rdata  = rdat_q;

  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> $onehot(dev_sel));
  assert_sel_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req |-> (dev_sel == '0));
  assert_done_after_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_req) |-> io_done);
  assert_disabled_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit_win && !ptr_en) |=> !cfg_req);
  assert_ptr_stable_txn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_ack) |=> $stable(cfg_reg) && $stable(cfg_fn) && $stable(cfg_wdata));
endmodule

// File: tb/cfg_port_bridge_test.sv
module cfg_port_bridge_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_req = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic io_done, cfg_req, cfg_wr;
  logic [31:0] io_rdata, cfg_wdata;
  logic [5:0] cfg_reg;
  logic [2:0] cfg_fn;
  logic [3:0] cfg_be;
  logic [31:0] dev_sel;
  logic cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = '0;

  int checks = 0, failures = 0;
  int ack_delay = 0;
  int req_cycles = 0;
  logic [31:0] exp_sel = '0;
  logic [31:0] tgt_data = '0;
  logic cap_wr; logic [3:0] cap_be; logic [31:0] cap_wdata, cap_sel;
  logic [5:0] cap_reg; logic [2:0] cap_fn;

  always #10 clk = ~clk;

  cfg_port_bridge uut (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr),
    .io_be(io_be), .io_wdata(io_wdata), .io_done(io_done), .io_rdata(io_rdata),
    .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_reg(cfg_reg), .cfg_fn(cfg_fn),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .dev_sel(dev_sel),
    .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // target model: acknowledges after ack_delay cycles of cfg_req
  always @(negedge clk) begin
    if (cfg_req) begin
      if (req_cycles == 0) begin
        cap_wr = cfg_wr; cap_be = cfg_be; cap_wdata = cfg_wdata;
        cap_reg = cfg_reg; cap_fn = cfg_fn; cap_sel = dev_sel;
      end
      if (dev_sel != exp_sel) begin
        checks++; failures++;
        $display("FAIL R4 select actual=%h expected=%h", dev_sel, exp_sel);
      end
      cfg_ack   = (req_cycles == ack_delay);
      cfg_rdata = tgt_data;
      req_cycles++;
    end else begin
      cfg_ack = 1'b0;
      if (rst_n && dev_sel != 0) begin
        checks++; failures++;
        $display("FAIL R4 idle select actual=%h expected=0", dev_sel);
      end
    end
  end

  task automatic io_access(input bit wr, input logic [15:0] addr, input logic [3:0] be,
                           input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    req_cycles = 0;
    io_req = 1'b1; io_wr = wr; io_addr = addr; io_be = be; io_wdata = wd;
    @(negedge clk);
    io_req = 1'b0;
    lat = 0;
    while (!io_done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    rd = io_rdata;
    @(negedge clk);
    chk(!io_done, "R9 done single cycle", {31'd0, io_done}, 32'd0);
  endtask

  function automatic logic [31:0] pat(input int d, input int f, input int r);
    return 32'hC000_0000 | (32'(d) << 16) | (32'(f) << 8) | 32'(r);
  endfunction

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd, ptrv, expv;
    int lat;
    repeat (3) @(negedge clk);
    chk(cfg_req == 0 && io_done == 0 && dev_sel == 0, "R10 reset outputs",
        {cfg_req, io_done, 30'd0}, 32'd0);
    rst_n = 1'b1;
    io_access(0, 16'h0CF8, 4'hF, 0, rd, lat);
    chk(rd == 0, "R10 pointer reset value", rd, 0);

    // full sweep over device slots
    for (int d = 0; d < 32; d++) begin
      int f = d % 8;
      int r = (d * 5) % 64;
      ptrv = 32'h8000_0000 | (32'h55 << 24) | (32'(d) << 11) | (32'(f) << 8) | (32'(r) << 2) | 32'h3;
      expv = ptrv & 32'h80FF_FFFC;
      io_access(1, 16'h0CF8, 4'hF, ptrv, rd, lat);
      io_access(0, 16'h0CF8, 4'hF, 0, rd, lat);
      chk(rd == expv, "R1 pointer readback", rd, expv);
      exp_sel = 32'd1 << d;
      tgt_data = pat(d, f, r);
      ack_delay = d % 5;
      io_access(0, 16'h0CFC, 4'hF, 0, rd, lat);
      chk(rd == tgt_data, "R5 read data", rd, tgt_data);
      chk(lat == ack_delay + 1, "R5 completion cycle", lat, ack_delay + 1);
      chk(req_cycles == ack_delay + 1, "R3 request length", req_cycles, ack_delay + 1);
      chk(cap_reg == r && cap_fn == f && cap_wr == 0, "R3 request fields",
          {cap_wr, cap_fn, cap_reg}, {1'b0, 3'(f), 6'(r)});
      chk(cap_sel == exp_sel, "R4 select bit", cap_sel, exp_sel);
      ack_delay = (d + 2) % 7;
      io_access(1, 16'h0CFC, 4'((d % 15) + 1), (32'(d) * 32'h0101_0101) ^ 32'h5A5A_5A5A, rd, lat);
      chk(cap_wr == 1 && cap_be == 4'((d % 15) + 1), "R3 write flag and enables",
          {cap_wr, cap_be}, {1'b1, 4'((d % 15) + 1)});
      chk(cap_wdata == ((32'(d) * 32'h0101_0101) ^ 32'h5A5A_5A5A), "R3 write data",
          cap_wdata, (32'(d) * 32'h0101_0101) ^ 32'h5A5A_5A5A);
      chk(lat == ack_delay + 1, "R3 write completion", lat, ack_delay + 1);
    end

    // timeout boundary (device 7)
    io_access(1, 16'h0CF8, 4'hF, 32'h8000_3808, rd, lat);
    exp_sel = 32'd1 << 7;
    tgt_data = 32'h1234_5678;
    ack_delay = 15;
    io_access(0, 16'h0CFC, 4'hF, 0, rd, lat);
    chk(rd == 32'h1234_5678 && lat == 16, "R6 ack in last cycle", rd, 32'h1234_5678);
    ack_delay = 99;
    io_access(0, 16'h0CFC, 4'hF, 0, rd, lat);
    chk(rd == 32'hFFFF_FFFF, "R6 timeout data", rd, 32'hFFFF_FFFF);
    chk(req_cycles == 16 && lat == 16, "R6 timeout length", req_cycles, 16);
    io_access(1, 16'h0CFC, 4'hF, 32'hDEAD_BEEF, rd, lat);
    chk(req_cycles == 16 && lat == 16, "R6 timeout write", lat, 16);

    // enable cleared
    ack_delay = 0;
    io_access(1, 16'h0CF8, 4'hF, 32'h0000_3808, rd, lat);
    io_access(0, 16'h0CFC, 4'hF, 0, rd, lat);
    chk(rd == 32'hFFFF_FFFF && lat == 0, "R2 disabled read", rd, 32'hFFFF_FFFF);
    chk(req_cycles == 0, "R2 no request on read", req_cycles, 0);
    io_access(1, 16'h0CFC, 4'hF, 32'h1111_1111, rd, lat);
    chk(req_cycles == 0 && lat == 0, "R2 no request on write", req_cycles, 0);

    // non-zero bus
    io_access(1, 16'h0CF8, 4'hF, 32'h8003_3808, rd, lat);
    io_access(0, 16'h0CFC, 4'hF, 0, rd, lat);
    chk(rd == 32'hFFFF_FFFF && lat == 0, "R7 other bus read", rd, 32'hFFFF_FFFF);
    chk(req_cycles == 0, "R7 no request", req_cycles, 0);

    // unrelated I/O addresses
    io_access(0, 16'h0080, 4'hF, 0, rd, lat);
    chk(rd == 32'hFFFF_FFFF && lat == 0, "R8 other address read", rd, 32'hFFFF_FFFF);
    io_access(1, 16'h0CF9, 4'hF, 32'h0, rd, lat);
    io_access(0, 16'h0CF8, 4'hF, 0, rd, lat);
    chk(rd == 32'h8003_3808, "R8 pointer untouched", rd, 32'h8003_3808);

    // lane writes
    io_access(1, 16'h0CF8, 4'hF, 32'hFFFF_FFFF, rd, lat);
    io_access(1, 16'h0CF8, 4'h1, 32'h0, rd, lat);
    io_access(0, 16'h0CF8, 4'hF, 0, rd, lat);
    chk(rd == 32'h80FF_FF00, "R1 lane 0 write", rd, 32'h80FF_FF00);
    io_access(1, 16'h0CF8, 4'h8, 32'h0, rd, lat);
    io_access(0, 16'h0CF8, 4'hF, 0, rd, lat);
    chk(rd == 32'h00FF_FF00, "R1 lane 3 write", rd, 32'h00FF_FF00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule